// File: doc/BRIEF.md
# Six-Bit Wiper Position Counter with One-Hot Tap Select

This block holds the position of one digitally controlled potentiometer wiper and turns that position into the select lines for its tap switches. The position is a volatile six-bit value. It can change in four ways: a recall of the power-up value (the contents of stored data register 0), a direct write from the host, a parallel transfer from one of the stored data registers, and a single-position step up or down. The stored registers sit outside this block. The block only receives the value that is to be transferred.

After reset the position is zero and the block waits for the recall. Until that recall arrives, every other request is ignored, so the tap output stays on the low end. Once it is recalled, the block serves one request per clock in a fixed order of priority: recall, then direct write, then transfer, then step. A step stops at the ends of the range and never wraps. The tap output is combinational from the position register and is always strictly one-hot.

Top module: `wiper_tap_ctrl`

## Requirements
- R1: After reset, wiperPos is 0 and tapSel has only bit 0 set.
- R2: Until the first recall request after reset, write, transfer and step requests have no effect, and the position stays 0.
- R3: A recall request loads recallVal into the position at the next clock edge. It takes priority over every other request in the same cycle.
- R4: A write request (once recalled, and with no recall pending) loads wrVal at the next clock edge.
- R5: A transfer request (with no recall or write in the same cycle) loads xferVal at the next clock edge.
- R6: When write and transfer requests arrive together, the write value is loaded.
- R7: A write or transfer request that arrives together with a step request is loaded, and the step is dropped.
- R8: A step request with stepUp=1 raises the position by one. At 63 (3Fh, the high end) it stays at 63.
- R9: A step request with stepUp=0 lowers the position by one. At 0 (the low end) it stays at 0.
- R10: tapSel has exactly one bit set, and that bit's index equals wiperPos: bit 0 is the low-end tap and bit 63 is the high-end tap.
- R11: In a cycle with no request, the position holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| recallReq | input | 1 | Power-up recall strobe |
| recallVal | input | 6 | Value of stored register 0 to recall |
| wrReq | input | 1 | Direct host write strobe |
| wrVal | input | 6 | Host write value |
| xferReq | input | 1 | Parallel transfer strobe |
| xferVal | input | 6 | Selected stored register value |
| stepReq | input | 1 | Single-position step strobe |
| stepUp | input | 1 | Step direction: 1 toward high end, 0 toward low end |
| wiperPos | output | 6 | Current wiper position |
| tapSel | output | 64 | One-hot tap switch select |

## Verification
The bench builds the block with its default six-bit position, so the full set of 64 codes and 64 tap lines is small enough to cover completely. Every code is written directly and checked against a one-hot vector computed by shifting. The position is then stepped across the whole range in both directions, so both saturation points are reached from their neighbours. Each pairwise collision between request types, and each request made before recall, is also driven.

// File: rtl/wtap_pkg.sv
package wtap_pkg;
  typedef struct packed {
    logic recall;
    logic wr;
    logic xfer;
    logic step;
    logic up;
  } wtapStrb_t;
endpackage

// File: rtl/wtap_ctrl.sv
module wtap_ctrl
  import wtap_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      recallReq,
  input  logic      wrReq,
  input  logic      xferReq,
  input  logic      stepReq,
  input  logic      stepUp,
  output wtapStrb_t strb
);
  logic recalled;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) recalled <= 1'b0;
    else if (recallReq) recalled <= 1'b1;
  end

  always_comb begin
    strb = '0;
    if (recallReq) begin
      strb.recall = 1'b1;
    end else if (recalled) begin
      if (wrReq) strb.wr = 1'b1;
      else if (xferReq) strb.xfer = 1'b1;
      else if (stepReq) begin
        strb.step = 1'b1;
        strb.up   = stepUp;
      end
    end
  end

  AST_STRB_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.recall, strb.wr, strb.xfer, strb.step})); // R6
  AST_NO_EARLY_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (!recalled && !recallReq) |-> !(strb.wr || strb.xfer || strb.step)); // R2
  AST_RECALL_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    recallReq |-> strb.recall); // R3
  AST_LOAD_OVER_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (recalled && (wrReq || xferReq)) |-> !strb.step); // R7
endmodule

// File: rtl/wtap_datapath.sv
module wtap_datapath
  import wtap_pkg::*;
#(
  parameter int POS_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  wtapStrb_t        strb,
  input  logic [POS_W-1:0] recallVal,
  input  logic [POS_W-1:0] wrVal,
  input  logic [POS_W-1:0] xferVal,
  output logic [POS_W-1:0] pos
);
  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};
  localparam logic [POS_W-1:0] POS_MIN = '0;

  logic [POS_W-1:0] posNext;

  always_comb begin
    posNext = pos;
    if (strb.recall) posNext = recallVal;
    else if (strb.wr) posNext = wrVal;
    else if (strb.xfer) posNext = xferVal;
    else if (strb.step) begin
      if (strb.up) posNext = (pos == POS_MAX) ? pos : pos + 1'b1;
      else         posNext = (pos == POS_MIN) ? pos : pos - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pos <= '0;
    else pos <= posNext;
  end

  AST_RECALL_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.recall |=> pos == $past(recallVal)); // R3
  AST_WR_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.wr |=> pos == $past(wrVal)); // R4
  AST_XFER_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.xfer |=> pos == $past(xferVal)); // R5
  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && strb.up && pos == POS_MAX) |=> pos == POS_MAX); // R8
  AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !strb.up && pos == POS_MIN) |=> pos == POS_MIN); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.recall || strb.wr || strb.xfer || strb.step) |=> $stable(pos)); // R11
endmodule

// File: rtl/wtap_decode.sv
module wtap_decode #(
  parameter int POS_W = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [POS_W-1:0]    pos,
  output logic [(1<<POS_W)-1:0] tapSel
);
  localparam int TAPS = 1 << POS_W;

  for (genvar i = 0; i < TAPS; i++) begin : gTap
    assign tapSel[i] = (pos == POS_W'(i));
  end

  AST_TAP_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $countones(tapSel) == 1); // R10
  AST_TAP_INDEX: assert property (@(posedge clk) disable iff (!rstN)
    tapSel[pos]); // R10
endmodule

// File: rtl/wiper_tap_ctrl.sv
module wiper_tap_ctrl
  import wtap_pkg::*;
#(
  parameter int POS_W = 6,
  localparam int TAPS = 1 << POS_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             recallReq,
  input  logic [POS_W-1:0] recallVal,
  input  logic             wrReq,
  input  logic [POS_W-1:0] wrVal,
  input  logic             xferReq,
  input  logic [POS_W-1:0] xferVal,
  input  logic             stepReq,
  input  logic             stepUp,
  output logic [POS_W-1:0] wiperPos,
  output logic [TAPS-1:0]  tapSel
);
  wtapStrb_t strb;

  wtap_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .recallReq(recallReq), .wrReq(wrReq),
    .xferReq(xferReq), .stepReq(stepReq), .stepUp(stepUp), .strb(strb)
  );

  wtap_datapath #(.POS_W(POS_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .recallVal(recallVal),
    .wrVal(wrVal), .xferVal(xferVal), .pos(wiperPos)
  );

  wtap_decode #(.POS_W(POS_W)) uDec (
    .clk(clk), .rstN(rstN), .pos(wiperPos), .tapSel(tapSel)
  );
endmodule

// File: tb/wiper_tap_ctrl_test.sv
module wiper_tap_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int POS_W = 6;
  localparam int TAPS = 1 << POS_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic recallReq = 1'b0, wrReq = 1'b0, xferReq = 1'b0, stepReq = 1'b0, stepUp = 1'b0;
  logic [POS_W-1:0] recallVal = '0, wrVal = '0, xferVal = '0;
  logic [POS_W-1:0] wiperPos;
  logic [TAPS-1:0]  tapSel;
  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wiper_tap_ctrl #(.POS_W(POS_W)) uut (
    .clk(clk), .rstN(rstN), .recallReq(recallReq), .recallVal(recallVal),
    .wrReq(wrReq), .wrVal(wrVal), .xferReq(xferReq), .xferVal(xferVal),
    .stepReq(stepReq), .stepUp(stepUp), .wiperPos(wiperPos), .tapSel(tapSel)
  );

  task automatic checkPos(input string req, input int expPos);
    logic [TAPS-1:0] expTap;
    expTap = TAPS'(1) << expPos;
    nChecks++;
    if (wiperPos !== POS_W'(expPos) || tapSel !== expTap) begin
      nFails++;
      $display("FAIL %s: pos=%0d tap=%h expected pos=%0d tap=%h",
               req, wiperPos, tapSel, expPos, expTap);
    end
  endtask

  // Drive a request set for one clock edge, then clear; sample at negedge after update.
  task automatic pulse(input logic rc, input logic wr, input logic xf,
                       input logic st, input logic up);
    @(negedge clk);
    recallReq = rc; wrReq = wr; xferReq = xf; stepReq = st; stepUp = up;
    @(negedge clk);
    recallReq = 0; wrReq = 0; xferReq = 0; stepReq = 0; stepUp = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int expPos;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkPos("R1 reset", 0);

    // R2: requests before recall are ignored
    wrVal = 6'd17; pulse(0, 1, 0, 0, 0); checkPos("R2 write before recall", 0);
    xferVal = 6'd40; pulse(0, 0, 1, 0, 0); checkPos("R2 xfer before recall", 0);
    pulse(0, 0, 0, 1, 1); checkPos("R2 step before recall", 0);

    // R3: recall, with priority over a simultaneous write
    recallVal = 6'h2A; wrVal = 6'd5;
    pulse(1, 1, 0, 0, 0); checkPos("R3 recall priority", 42);
    recallVal = 6'd9; pulse(1, 0, 1, 1, 1); checkPos("R3 recall over xfer/step", 9);

    // R11: idle hold
    repeat (4) @(negedge clk);
    checkPos("R11 idle hold", 9);

    // R4 + R10: exhaustive direct write sweep
    for (int v = 0; v < TAPS; v++) begin
      wrVal = POS_W'(v); pulse(0, 1, 0, 0, 0);
      checkPos("R4 R10 write sweep", v);
    end
    // R5: transfer sweep
    for (int v = TAPS - 1; v >= 0; v--) begin
      xferVal = POS_W'(v); pulse(0, 0, 1, 0, 0);
      checkPos("R5 xfer sweep", v);
    end

    // R6: write wins over transfer
    wrVal = 6'd3; xferVal = 6'd60; pulse(0, 1, 1, 0, 0); checkPos("R6 write over xfer", 3);
    // R7: loads win over step
    wrVal = 6'd20; pulse(0, 1, 0, 1, 1); checkPos("R7 write over step", 20);
    xferVal = 6'd31; pulse(0, 0, 1, 1, 0); checkPos("R7 xfer over step", 31);

    // R8: step up from 0 to top, then saturate
    wrVal = 6'd0; pulse(0, 1, 0, 0, 0);
    expPos = 0;
    for (int k = 0; k < TAPS + 2; k++) begin
      pulse(0, 0, 0, 1, 1);
      expPos = (expPos == TAPS - 1) ? expPos : expPos + 1;
      checkPos("R8 R10 step up", expPos);
    end
    // R9: step down to bottom, then saturate
    for (int k = 0; k < TAPS + 2; k++) begin
      pulse(0, 0, 0, 1, 0);
      expPos = (expPos == 0) ? 0 : expPos - 1;
      checkPos("R9 R10 step down", expPos);
    end

    // R1: reset again mid-run
    wrVal = 6'd50; pulse(0, 1, 0, 0, 0);
    @(negedge clk); rstN = 1'b0; @(negedge clk); rstN = 1'b1; @(negedge clk);
    checkPos("R1 re-reset", 0);
    wrVal = 6'd11; pulse(0, 1, 0, 0, 0); checkPos("R2 write after re-reset", 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule